// File: doc/BRIEF.md
# Serial CRC-8 Engine for Single-Wire Identity Codes

This block computes and checks the 8-bit cyclic redundancy code that protects a 64-bit device identity on a single-wire bus. The code is fed one bit at a time, least significant bit first, into an 8-bit shift register with XOR feedback for the polynomial x^8 + x^5 + x^4 + 1. The register starts from zero. After the 56 data bits (an 8-bit family code followed by a 48-bit serial number) it holds the check byte. When the check byte is then shifted in as well, the register returns to zero.

There are two ways to drive the engine. In manual mode the caller supplies a bit and a shift strobe on each cycle, then reads the running register and a zero-residue flag. In automatic mode the caller loads a whole 64-bit code in one cycle. A small sequencer then shifts all 64 bits through the register and reports the result as a single-cycle pass or fail pulse.

Top module: `crc8_serial_engine`

## Requirements
- R1: While reset is active and after it is released, `crcOut` is 0x00, `zeroRes` is 1, and `busy`, `crcOk` and `crcErr` are 0.
- R2: When `clear` is high at a clock edge, `crcOut` becomes 0x00 after that edge, whatever `shiftEn` or `bitIn` hold in the same cycle.
- R3: When `shiftEn` is high at an edge (with `clear` low and the engine idle), the register updates as follows: f = crcOut[0] XOR bitIn; the register shifts right by one; then f is XORed into bits 7, 3 and 2 (reflected mask 0x8C).
- R4: When `clear`, `shiftEn` and `codeLoad` are all low and the engine is idle, `crcOut` holds its value.
- R5: Starting from zero, shifting in the 56 low bits of a code (bit 0 first) leaves the check byte of those bits in `crcOut`.
- R6: If the 8 check-byte bits are then shifted in, LSB first, `crcOut` becomes 0x00 and `zeroRes` is 1. `zeroRes` is 1 exactly when `crcOut` is 0x00.
- R7: A `codeLoad` pulse while idle clears the register and captures `codeIn`, which is laid out as family code in bits 7:0, serial number in bits 55:8 and check byte in bits 63:56. `busy` goes high after that edge and stays high for 65 cycles: 64 shifts followed by one check cycle. A load takes precedence over a `shiftEn` in the same cycle.
- R8: In the cycle in which `busy` falls, exactly one of `crcOk` and `crcErr` is high for one cycle. It is `crcOk` if the residue after all 64 bits is 0x00, and `crcErr` otherwise.
- R9: While `busy` is high, `shiftEn`, `bitIn` and `codeLoad` have no effect on the run or its result.
- R10: `clear` during a run aborts it. After that edge `busy` is low and `crcOut` is 0x00, and neither `crcOk` nor `crcErr` follows.
- R11: The automatic run feeds `codeIn` bit 0 first, so its final residue equals that of manual shifting of the same 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of the register; aborts a run |
| shiftEn | input | 1 | Manual shift strobe |
| bitIn | input | 1 | Manual serial data bit |
| codeLoad | input | 1 | Starts an automatic 64-bit run |
| codeIn | input | 64 | Code captured by `codeLoad` |
| crcOut | output | 8 | Current CRC register |
| zeroRes | output | 1 | Register is zero |
| busy | output | 1 | Automatic run in progress |
| crcOk | output | 1 | Run passed (one-cycle pulse) |
| crcErr | output | 1 | Run failed (one-cycle pulse) |

## Verification
`clear` can arrive in the same cycle as a manual shift, and it can also arrive in the middle of an automatic run. The bench provokes the first case from a nonzero register with a one on `bitIn`, which would otherwise produce a nonzero value. It provokes the second case several dozen cycles into a run. In both cases the expected outcome is a zero register, and in the abort case also a dropped `busy` with no pass or fail pulse. A load in the same cycle as `shiftEn` is judged by checking that the final verdict matches that of the loaded code alone.

// File: rtl/crc8_pkg.sv
package crc8_pkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clr;      // zero the register
    logic load;     // zero the register, capture a code
    logic shift;    // advance by one bit
    logic useCode;  // take the bit from the captured code
  } crcStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CHECK = 2'd2
  } runState_t;

endpackage

// File: rtl/crc8_datapath.sv
module crc8_datapath
  import crc8_pkg::*;
#(
  parameter int CRC_W = 8,
  parameter int CODE_W = 64,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  crcStrobe_t        stb,
  input  logic              bitIn,
  input  logic [CODE_W-1:0] codeIn,
  output logic [CRC_W-1:0]  crcOut,
  output logic              residueZero
);

  logic [CRC_W-1:0]  crcReg;
  logic [CODE_W-1:0] codeReg;
  logic              dIn;
  logic [CRC_W-1:0]  crcNext;

  assign dIn = stb.useCode ? codeReg[0] : bitIn;

  // one reflected LFSR step
  always_comb begin
    logic fb;
    fb = crcReg[0] ^ dIn;
    crcNext = (crcReg >> 1) ^ (fb ? POLY_REFL : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg  <= '0;
      codeReg <= '0;
    end else if (stb.clr) begin
      crcReg <= '0;
    end else if (stb.load) begin
      crcReg  <= '0;
      codeReg <= codeIn;
    end else if (stb.shift) begin
      crcReg <= crcNext;
      if (stb.useCode) codeReg <= codeReg >> 1;
    end
  end

  assign crcOut      = crcReg;
  assign residueZero = (crcReg == '0);

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clr |=> (crcOut == '0));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clr && !stb.load && !stb.shift) |=> $stable(crcOut));

  p_load_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.load && !stb.clr) |=> (crcOut == '0));

endmodule

// File: rtl/crc8_control.sv
module crc8_control
  import crc8_pkg::*;
#(
  parameter int CODE_W = 64,
  localparam int CNT_W = $clog2(CODE_W)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shiftEn,
  input  logic       codeLoad,
  input  logic       residueZero,
  output crcStrobe_t stb,
  output logic       busy,
  output logic       crcOk,
  output logic       crcErr
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);

  runState_t       state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    stb.clr     = clear;
    stb.load    = !clear && (state == ST_IDLE) && codeLoad;
    stb.shift   = !clear && ((state == ST_RUN) ||
                  ((state == ST_IDLE) && !codeLoad && shiftEn));
    stb.useCode = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      crcOk  <= 1'b0;
      crcErr <= 1'b0;
    end else begin
      crcOk  <= 1'b0;
      crcErr <= 1'b0;
      if (clear) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE: if (codeLoad) begin
            state  <= ST_RUN;
            bitCnt <= '0;
          end
          ST_RUN: begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= ST_CHECK;
          end
          ST_CHECK: begin
            crcOk  <= residueZero;
            crcErr <= !residueZero;
            state  <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy = (state != ST_IDLE);

  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(crcOk && crcErr));

  p_ok_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    crcOk |=> !crcOk);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    crcErr |=> !crcErr);

  p_verdict_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (crcOk || crcErr) |-> (!busy && $past(busy)));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!busy && !crcOk && !crcErr));

  p_run_continues_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && bitCnt != LAST_BIT && !clear) |=> (state == ST_RUN));

endmodule

// File: rtl/crc8_serial_engine.sv
module crc8_serial_engine
  import crc8_pkg::*;
#(
  parameter int CRC_W = 8,
  parameter int CODE_W = 64,
  parameter logic [CRC_W-1:0] POLY_REFL = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shiftEn,
  input  logic              bitIn,
  input  logic              codeLoad,
  input  logic [CODE_W-1:0] codeIn,
  output logic [CRC_W-1:0]  crcOut,
  output logic              zeroRes,
  output logic              busy,
  output logic              crcOk,
  output logic              crcErr
);

  crcStrobe_t stb;
  logic       residueZero;

  crc8_control #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .shiftEn(shiftEn),
    .codeLoad(codeLoad), .residueZero(residueZero), .stb(stb),
    .busy(busy), .crcOk(crcOk), .crcErr(crcErr)
  );

  crc8_datapath #(.CRC_W(CRC_W), .CODE_W(CODE_W), .POLY_REFL(POLY_REFL)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .bitIn(bitIn), .codeIn(codeIn),
    .crcOut(crcOut), .residueZero(residueZero)
  );

  assign zeroRes = residueZero;

endmodule

// File: tb/tb_crc8_serial_engine.sv
module tb_crc8_serial_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0, shiftEn = 1'b0, bitIn = 1'b0, codeLoad = 1'b0;
  logic [63:0] codeIn = '0;
  logic [7:0]  crcOut;
  logic        zeroRes, busy, crcOk, crcErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  crc8_serial_engine dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .shiftEn(shiftEn), .bitIn(bitIn),
    .codeLoad(codeLoad), .codeIn(codeIn), .crcOut(crcOut), .zeroRes(zeroRes),
    .busy(busy), .crcOk(crcOk), .crcErr(crcErr)
  );

  function automatic logic [7:0] modelStep(input logic [7:0] c, input logic d);
    logic f;
    logic [7:0] n;
    f = c[0] ^ d;
    n = {f, c[7:1]};
    n[3] = n[3] ^ f;
    n[2] = n[2] ^ f;
    return n;
  endfunction

  function automatic logic [7:0] modelCrc(input logic [63:0] v, input int nBits);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < nBits; i++) c = modelStep(c, v[i]);
    return c;
  endfunction

  function automatic logic [63:0] makeCode(input logic [55:0] body);
    return {modelCrc({8'h00, body}, 56), body};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shiftOne(input logic b);
    shiftEn = 1'b1; bitIn = b;
    @(negedge clk);
    shiftEn = 1'b0;
  endtask

  task automatic doClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  // automatic run; noise toggles manual inputs during busy
  task automatic runCode(input logic [63:0] code, input bit noise, input string req);
    int busyCycles = 0;
    codeIn = code; codeLoad = 1'b1;
    @(negedge clk);
    codeLoad = 1'b0;
    codeIn = '0;
    check({req, " R7 busy rises"}, busy, 1);
    while (busy && busyCycles < 200) begin
      if (noise) begin
        shiftEn  = 1'($urandom);
        bitIn    = 1'($urandom);
        codeLoad = 1'($urandom);
        codeIn   = {$urandom, $urandom};
      end
      busyCycles++;
      check({req, " R9 no verdict while busy"}, {crcOk, crcErr}, 2'b00);
      @(negedge clk);
    end
    shiftEn = 1'b0; codeLoad = 1'b0;
    check({req, " R7 busy length"}, busyCycles, 65);
    check({req, " R8 verdict"}, {crcOk, crcErr},
          (modelCrc(code, 64) == 8'h00) ? 2'b10 : 2'b01);
    check({req, " R11 residue"}, crcOut, modelCrc(code, 64));
    @(negedge clk);
    check({req, " R8 one-cycle pulse"}, {crcOk, crcErr}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp;
    logic [63:0] code;
    int unused;
    unused = $urandom(32'h00C0FFEE);

    repeat (2) @(negedge clk);
    // R1: outputs during reset
    check("R1 crcOut in reset", crcOut, 8'h00);
    check("R1 flags in reset", {zeroRes, busy, crcOk, crcErr}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 crcOut after reset", crcOut, 8'h00);
    check("R1 flags after reset", {zeroRes, busy, crcOk, crcErr}, 4'b1000);

    // R3: single steps, directed then random
    shiftOne(1'b1);
    check("R3 step from zero with one", crcOut, 8'h8C);
    exp = 8'h8C;
    for (int i = 0; i < 40; i++) begin
      logic b;
      b = 1'($urandom);
      exp = modelStep(exp, b);
      shiftOne(b);
      check("R3 random step", crcOut, exp);
      check("R6 flag tracks zero", zeroRes, exp == 8'h00);
    end

    // R4: hold while idle with no strobes, bitIn toggling
    for (int i = 0; i < 5; i++) begin
      bitIn = ~bitIn;
      @(negedge clk);
      check("R4 hold", crcOut, exp);
    end

    // R2: clear beats a simultaneous shift of a one
    if (crcOut == 8'h00) shiftOne(1'b1);
    clear = 1'b1; shiftEn = 1'b1; bitIn = 1'b1;
    @(negedge clk);
    clear = 1'b0; shiftEn = 1'b0;
    check("R2 clear priority", crcOut, 8'h00);

    // R5/R6: random identities, generate then verify
    for (int t = 0; t < 30; t++) begin
      code = makeCode({$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF);
      if (t == 0) code = makeCode(56'h0);
      if (t == 1) code = makeCode({56{1'b1}});
      doClear();
      for (int i = 0; i < 56; i++) shiftOne(code[i]);
      check("R5 generated check byte", crcOut, code[63:56]);
      for (int i = 56; i < 64; i++) shiftOne(code[i]);
      check("R6 residue zero", crcOut, 8'h00);
      check("R6 zero flag", zeroRes, 1'b1);
    end

    // R7/R8/R11: automatic runs, good and corrupted
    for (int t = 0; t < 12; t++) begin
      code = makeCode({$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF);
      if (t % 3 == 1) code[$urandom_range(63, 0)] ^= 1'b1;
      if (t % 3 == 2) code[63:56] ^= 8'h01;
      runCode(code, 1'b0, "auto");
    end

    // R9: manual inputs toggled during runs
    for (int t = 0; t < 6; t++) begin
      code = makeCode({$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF);
      if (t[0]) code[7] ^= 1'b1;
      runCode(code, 1'b1, "R9 noise");
    end

    // R7: load together with shiftEn, starting from a nonzero register
    doClear();
    shiftOne(1'b1);
    code = makeCode(56'h12_3456_789A_BC01);
    shiftEn = 1'b1; bitIn = 1'b1;
    runCode(code, 1'b0, "R7 load over shift");

    // R10: abort mid-run
    code = makeCode(56'h00_00DE_ADBE_EF02);
    codeIn = code; codeLoad = 1'b1;
    @(negedge clk);
    codeLoad = 1'b0;
    repeat (30) @(negedge clk);
    doClear();
    check("R10 busy after abort", busy, 1'b0);
    check("R10 crc after abort", crcOut, 8'h00);
    for (int i = 0; i < 70; i++) begin
      check("R10 no verdict after abort", {crcOk, crcErr, busy}, 3'b000);
      @(negedge clk);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule